// File: doc/BRIEF.md
# Write-One Command GPIO Bank

This block is a bank of general-purpose pins (eight or four, chosen by parameter) that software drives through a single 32-bit register. Every write is a batch of independent one-shot commands: a 1 in a given bit position asks one pin to drive low, to drive high, to become an output or to become an input. A 0 in any position asks for nothing. Since no command depends on the other bits of the word, several software agents can share the bank without read-modify-write sequences and without locking.

The same register, when read, reports the bank. The odd bits of the lower half carry each pin's input level, taken through a two-flop synchroniser. The even bits of the upper half carry each pin's output enable. All other bits read as 0. Each pin keeps an output level latch, and a two-state direction machine. The states are `MODE_INPUT` (reset state, driver off) and `MODE_OUTPUT` (driver on). Two transitions join them: ENABLE goes from `MODE_INPUT` to `MODE_OUTPUT` on an output command with no input command in the same write, and RELEASE goes from `MODE_OUTPUT` to `MODE_INPUT` on an input command. Any other write leaves the state where it is. To turn a pin into an output at a known level, software writes the level command first and the enable command second. The pin then drives the wanted level from its first enabled cycle.

Top module: `gpio_ss_bank`

## Requirements
- R1: While reset is held and at its release, every output latch is 0, every pin is in `MODE_INPUT` (`pin_oe` all 0) and `rd_data` is 0.
- R2: A write with bit 2n set drives latch n to 0 and a write with bit 2n+1 set drives it to 1. The latch changes at the clock edge that accepts the write. When both bits are set in one write, the latch becomes 1.
- R3: A write with bit 2n+16 set moves pin n to `MODE_OUTPUT` (ENABLE) and a write with bit 2n+17 set moves it to `MODE_INPUT` (RELEASE). The change happens at the accepting edge. When both bits are set in one write, the pin ends in `MODE_INPUT`.
- R4: Zero bits in a write, and clock edges with `wr_en` low, leave every output latch and every direction unchanged.
- R5: Read bit 2n+1 equals `pin_in[n]` as sampled two clock edges earlier, which is the two-flop synchroniser delay.
- R6: Read bit 2n+16 equals pin n's output enable. Every even bit below 16 and every bit 2n+17 reads 0.
- R7: A level command applies to the latch in either direction state. A later ENABLE write carrying no level bits leaves the latch unchanged, so the pin drives the level written earlier.
- R8: With `PIN_COUNT` = 4, read bits 8..15 and 24..31 are always 0, and the command bits of pins 4..7 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bank clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Write strobe; `wr_data` is taken at this edge |
| wr_data | input | 32 | Command word |
| rd_data | output | 32 | Status word: synchronised levels and output enables |
| pin_in | input | PIN_COUNT | Pad input levels |
| pin_out | output | PIN_COUNT | Output level latches |
| pin_oe | output | PIN_COUNT | Output enables (1 in `MODE_OUTPUT`) |

## Verification
The assertions check on every cycle the per-pin priority of the level and direction commands, the hold behaviour when no command is given, the two-edge synchroniser delay from `pin_in` to the read word, and the zero pattern of the unused read bits in both widths. Only the bench's scenarios can show the reset state and the level-then-enable sequence of R7. They also show that the modelled latch and direction of all pins stay right over long mixed runs of commands. In those runs the bench checks each write against a model it keeps itself, for the eight-pin and four-pin variants side by side.

// File: rtl/gpio_ss_pkg.sv
package gpio_ss_pkg;

    localparam int WORD_W   = 32;
    localparam int CFG_BASE = 16;
    localparam int MAX_PINS = 8;

    typedef enum logic {
        MODE_INPUT  = 1'b0,
        MODE_OUTPUT = 1'b1
    } pin_mode_e;

    typedef struct packed {
        logic drive_lo;
        logic drive_hi;
        logic go_out;
        logic go_in;
    } pin_cmd_t;

    function automatic logic [WORD_W-1:0] live_mask(input int pins);
        logic [WORD_W-1:0] m;
        m = '0;
        for (int n = 0; n < pins; n++) begin
            m[2*n+1]        = 1'b1;
            m[2*n+CFG_BASE] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/gpio_ss_cmd_decode.sv
module gpio_ss_cmd_decode
    import gpio_ss_pkg::*;
#(
    parameter int PIN_COUNT = 8
) (
    input  logic                           wr_en,
    input  logic [WORD_W-1:0]              wr_data,
    output pin_cmd_t [PIN_COUNT-1:0]       cmd
);

    logic unused_word_bits;
    assign unused_word_bits = ^wr_data;

    for (genvar n = 0; n < PIN_COUNT; n++) begin : g_pin
        assign cmd[n].drive_lo = wr_en & wr_data[2*n];
        assign cmd[n].drive_hi = wr_en & wr_data[2*n+1];
        assign cmd[n].go_out   = wr_en & wr_data[2*n+CFG_BASE];
        assign cmd[n].go_in    = wr_en & wr_data[2*n+CFG_BASE+1];
    end

endmodule

// File: rtl/gpio_ss_pin_ctrl.sv
module gpio_ss_pin_ctrl
    import gpio_ss_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  pin_cmd_t cmd,
    output logic     drive_level,
    output logic     drive_en
);

    pin_mode_e mode_q, mode_d;
    logic      level_q;

    // Direction state register
    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= MODE_INPUT;
        else        mode_q <= mode_d;
    end

    // Transitions: RELEASE has priority over ENABLE
    always_comb begin
        mode_d = mode_q;
        unique case (mode_q)
            MODE_INPUT:  if (cmd.go_out && !cmd.go_in) mode_d = MODE_OUTPUT;
            MODE_OUTPUT: if (cmd.go_in)                mode_d = MODE_INPUT;
            default:                                   mode_d = MODE_INPUT;
        endcase
    end

    // Level latch: high command wins over low
    always_ff @(posedge clk) begin
        if (!rst_n)            level_q <= 1'b0;
        else if (cmd.drive_hi) level_q <= 1'b1;
        else if (cmd.drive_lo) level_q <= 1'b0;
    end

    // Outputs
    always_comb begin
        drive_level = level_q;
        unique case (mode_q)
            MODE_OUTPUT: drive_en = 1'b1;
            default:     drive_en = 1'b0;
        endcase
    end

endmodule

// File: rtl/gpio_ss_sync.sv
module gpio_ss_sync #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [WIDTH-1:0] stage1_q, stage2_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= async_in;
            stage2_q <= stage1_q;
        end
    end

    assign sync_out = stage2_q;

endmodule

// File: rtl/gpio_ss_bank.sv
module gpio_ss_bank
    import gpio_ss_pkg::*;
#(
    parameter int PIN_COUNT = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [WORD_W-1:0]    wr_data,
    output logic [WORD_W-1:0]    rd_data,
    input  logic [PIN_COUNT-1:0] pin_in,
    output logic [PIN_COUNT-1:0] pin_out,
    output logic [PIN_COUNT-1:0] pin_oe
);

    pin_cmd_t [PIN_COUNT-1:0] cmd;
    logic     [PIN_COUNT-1:0] level_sync;

    gpio_ss_cmd_decode #(.PIN_COUNT(PIN_COUNT)) u_decode (
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .cmd     (cmd)
    );

    for (genvar n = 0; n < PIN_COUNT; n++) begin : g_pin
        gpio_ss_pin_ctrl u_ctrl (
            .clk         (clk),
            .rst_n       (rst_n),
            .cmd         (cmd[n]),
            .drive_level (pin_out[n]),
            .drive_en    (pin_oe[n])
        );
    end

    gpio_ss_sync #(.WIDTH(PIN_COUNT)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_in),
        .sync_out (level_sync)
    );

    always_comb begin
        rd_data = '0;
        for (int n = 0; n < PIN_COUNT; n++) begin
            rd_data[2*n+1]        = level_sync[n];
            rd_data[2*n+CFG_BASE] = pin_oe[n];
        end
    end

endmodule

// File: rtl/gpio_ss_bank_chk.sv
module gpio_ss_bank_chk
    import gpio_ss_pkg::*;
#(
    parameter int PIN_COUNT = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 wr_en,
    input logic [WORD_W-1:0]    wr_data,
    input logic [WORD_W-1:0]    rd_data,
    input logic [PIN_COUNT-1:0] pin_in,
    input logic [PIN_COUNT-1:0] pin_out,
    input logic [PIN_COUNT-1:0] pin_oe
);

    localparam logic [WORD_W-1:0] LIVE = live_mask(PIN_COUNT);

    logic [1:0] run_cnt;
    always_ff @(posedge clk) begin
        if (!rst_n)           run_cnt <= '0;
        else if (run_cnt != 3) run_cnt <= run_cnt + 2'd1;
    end

    for (genvar n = 0; n < PIN_COUNT; n++) begin : g_pin
        // R2
        level_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
            wr_en && wr_data[2*n+1] |=> pin_out[n]);
        // R2
        level_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
            wr_en && wr_data[2*n] && !wr_data[2*n+1] |=> !pin_out[n]);
        // R3
        dir_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
            wr_en && wr_data[2*n+CFG_BASE+1] |=> !pin_oe[n]);
        // R3
        dir_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
            wr_en && wr_data[2*n+CFG_BASE] && !wr_data[2*n+CFG_BASE+1] |=> pin_oe[n]);
        // R4
        hold_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !(wr_en && (wr_data[2*n] || wr_data[2*n+1]
                        || wr_data[2*n+CFG_BASE] || wr_data[2*n+CFG_BASE+1]))
            |=> $stable(pin_out[n]) && $stable(pin_oe[n]));
        // R5
        sync_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
            run_cnt >= 2 |-> rd_data[2*n+1] == $past(pin_in[n], 2));
        // R6
        oe_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
            rd_data[2*n+CFG_BASE] == pin_oe[n]);
    end

    // R6, R8
    dead_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data & ~LIVE) == '0);

endmodule

bind gpio_ss_bank gpio_ss_bank_chk #(.PIN_COUNT(PIN_COUNT)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .rd_data (rd_data),
    .pin_in  (pin_in),
    .pin_out (pin_out),
    .pin_oe  (pin_oe)
);

// File: tb/gpio_ss_bank_test.sv
`timescale 1ns/1ps
module gpio_ss_bank_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [7:0]  pin_in = '0;
    logic [31:0] rd_data, rd_narrow;
    logic [7:0]  pin_out, pin_oe;
    logic [3:0]  out_narrow, oe_narrow;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    logic [7:0] exp_out = '0, exp_oe = '0;

    always #10 clk = ~clk;

    gpio_ss_bank #(.PIN_COUNT(8)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
    );

    gpio_ss_bank #(.PIN_COUNT(4)) uut_narrow (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_narrow), .pin_in(pin_in[3:0]), .pin_out(out_narrow),
        .pin_oe(oe_narrow)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] read_word(input int pins, input logic [7:0] lvl,
                                              input logic [7:0] oe);
        logic [31:0] r = '0;
        for (int n = 0; n < pins; n++) begin
            r[2*n+1]  = lvl[n];
            r[2*n+16] = oe[n];
        end
        return r;
    endfunction

    // Bench model of one write, from R2 and R3
    task automatic model_write(input logic [31:0] w);
        for (int n = 0; n < 8; n++) begin
            if (w[2*n+1])      exp_out[n] = 1'b1;
            else if (w[2*n])   exp_out[n] = 1'b0;
            if (w[2*n+17])     exp_oe[n] = 1'b0;
            else if (w[2*n+16]) exp_oe[n] = 1'b1;
        end
    endtask

    // Drive one write, check latches after the accepting edge, read after two edges
    task automatic apply(input logic [31:0] w, input logic [7:0] lvl, input string tag);
        @(negedge clk);
        wr_en = 1'b1; wr_data = w; pin_in = lvl;
        model_write(w);
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0; wr_data = 32'hFFFF_FFFF;
        check(pin_out == exp_out, {tag, " out"}, {24'd0, pin_out}, {24'd0, exp_out});
        check(pin_oe == exp_oe, {tag, " oe"}, {24'd0, pin_oe}, {24'd0, exp_oe});
        check(out_narrow == exp_out[3:0], {"R8 narrow out ", tag},
              {28'd0, out_narrow}, {28'd0, exp_out[3:0]});
        check(oe_narrow == exp_oe[3:0], {"R8 narrow oe ", tag},
              {28'd0, oe_narrow}, {28'd0, exp_oe[3:0]});
        @(posedge clk);
        @(negedge clk);
        // R4: idle edge with wr_en low and all-ones data left state alone
        check(pin_out == exp_out && pin_oe == exp_oe, "R4 idle hold",
              {16'd0, pin_oe, pin_out}, {16'd0, exp_oe, exp_out});
        // R5, R6
        check(rd_data == read_word(8, lvl, exp_oe), "R5/R6 read word R5 R6",
              rd_data, read_word(8, lvl, exp_oe));
        check(rd_narrow == read_word(4, lvl, exp_oe), "R8 narrow read",
              rd_narrow, read_word(4, lvl, exp_oe));
    endtask

    initial begin
        #(200000 * 20);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        pin_in = 8'hFF;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1
        check(pin_out == 0 && pin_oe == 0, "R1 reset latches",
              {16'd0, pin_oe, pin_out}, 32'd0);
        check(rd_data == 0, "R1 reset read", rd_data, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(pin_out == 0 && pin_oe == 0 && out_narrow == 0 && oe_narrow == 0,
              "R1 after release", {16'd0, pin_oe, pin_out}, 32'd0);

        // R2 directed: both level bits on pin 0 -> high
        apply(32'h0000_0003, 8'h00, "R2 both level bits");
        // R3 directed: enable pin 0, then both direction bits -> input
        apply(32'h0001_0000, 8'h00, "R3 enable");
        apply(32'h0003_0000, 8'h00, "R3 both dir bits");
        // R7: level on an input pin, then enable with no level bits
        apply(32'h0000_0080, 8'h5A, "R7 level while input");
        check(pin_out[3] == 1'b1 && pin_oe[3] == 1'b0, "R7 latched not driven",
              {30'd0, pin_oe[3], pin_out[3]}, 32'd1);
        apply(32'h0040_0000, 8'hA5, "R7 enable");
        check(pin_out[3] == 1'b1 && pin_oe[3] == 1'b1, "R7 drives earlier level",
              {30'd0, pin_oe[3], pin_out[3]}, 32'd3);
        // R4: write of all zeros
        apply(32'h0000_0000, 8'h3C, "R4 zero write");
        // R8: commands only for pins 4..7
        apply(32'hFF00_AA00, 8'hF0, "R8 upper pins");

        // Sweep of mixed command words
        for (int s = 0; s < 400; s++) begin
            logic [15:0] lo, hi;
            lo = 16'(s * 16'h9E37 + 16'h5A3C);
            hi = 16'(s * 16'h6D2B) ^ 16'(s << 3);
            if (s % 16 == 5) begin lo = '0; hi = '0; end
            apply({hi, lo}, 8'(s * 37 + 11), "R2/R3 sweep R2 R3");
        end

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule